// File: doc/BRIEF.md
# Byte-Serial Instruction Sequencer with Dual Accumulators

This core runs a small 8-bit instruction set from a byte-wide memory with a 16-bit address space. Every instruction begins with one opcode byte. The opcode is decoded as soon as it arrives, and that decode alone sets how many operand bytes follow: none, one or two. The operand bytes are collected one per cycle. When a direct address is named, one more cycle reads the data byte, and then the instruction completes.

There are two 8-bit accumulators, called A and B, and a 16-bit program counter. The core supports four addressing forms:

- an implied form: halt, and every undefined opcode, which acts as a one-byte no-op;
- an immediate form: add to A, AND into A, and AND into B;
- a direct form with a 16-bit address: load A, and add to A;
- a PC-relative branch with a signed 8-bit displacement.

The memory port reads combinationally: read data must be valid in the same cycle as the address. The accumulators and the program counter are brought out so that an environment can observe the results of a program.

Top module: `byte_exec_core`

## Requirements
- R1: While rst_ni is low, pc_o equals RESET_PC, acc_a_o equals ACC_A_INIT, acc_b_o equals ACC_B_INIT, halt_o is 0, and mem_addr_o presents RESET_PC as the first fetch address.
- R2: Each instruction starts with a read of its opcode at the current PC. Any opcode other than 0x3A, 0xBB, 0xC6, 0x84, 0xC4, 0x20 and 0x3E is a one-byte no-op: it takes one cycle, leaves A and B unchanged, and the next fetch comes from the opcode address plus 1.
- R3: Opcode 0xC6 adds the following byte to A modulo 256. The next opcode is read from the opcode address plus 2.
- R4: Opcode 0x84 replaces A with A AND the following byte. Opcode 0xC4 replaces B with B AND the following byte. Each of them leaves the other accumulator unchanged, and the next opcode comes from the opcode address plus 2.
- R5: Opcode 0x3A loads A from memory at a 16-bit address. The first byte after the opcode is the low half of that address and the second byte is the high half. The next opcode comes from the opcode address plus 3.
- R6: Opcode 0xBB adds the byte at a direct address, assembled low byte first, to A modulo 256. The next opcode comes from the opcode address plus 3.
- R7: Opcode 0x20 continues fetching at the opcode address + 2 + the following byte, where that byte is read as a signed two's-complement value. The sum wraps modulo 65536.
- R8: Opcode 0x3E raises halt_o. From then on, pc_o holds the halt opcode address plus 1, and acc_a_o, acc_b_o and mem_addr_o do not change until reset.
- R9: mem_we_o stays 0 at all times.
- R10: Each instruction takes a fixed number of cycles, with one memory read per cycle:
  - 1 cycle for no-op and halt;
  - 2 cycles for immediate instructions and for the branch;
  - 4 cycles for direct-address instructions: opcode, low address byte, high address byte, then the data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 16 | Memory address of the current read |
| mem_rdata_i | input | 8 | Read data for mem_addr_o, valid in the same cycle |
| mem_wdata_o | output | 8 | Write data (presents A) |
| mem_we_o | output | 1 | Write enable, never asserted |
| halt_o | output | 1 | High once a halt opcode has run |
| acc_a_o | output | 8 | Accumulator A |
| acc_b_o | output | 8 | Accumulator B |
| pc_o | output | 16 | Program counter |

## Verification
The hardest cases to reach from the ports are these: a backward branch, a branch whose target wraps below address zero, and a direct address whose two bytes would give a different location if they were swapped. Short hand-built programs cover each case. One program branches forward over trap bytes and then backward. One branches with a displacement of 0x80 from address 0 and halts at 0xFF82. One places distinct data at 0x0200 and at 0x0002, so that a wrong byte order loads the wrong value. A behavioural interpreter in the bench predicts the address of every cycle, so a wrong instruction length shows up in the first cycle where it has an effect.

// File: rtl/byte_exec_pkg.sv
package byte_exec_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;

  localparam logic [BYTE_W-1:0] OPC_LDA_DIR  = 8'h3A;
  localparam logic [BYTE_W-1:0] OPC_ADDA_DIR = 8'hBB;
  localparam logic [BYTE_W-1:0] OPC_ADDA_IMM = 8'hC6;
  localparam logic [BYTE_W-1:0] OPC_ANDA_IMM = 8'h84;
  localparam logic [BYTE_W-1:0] OPC_ANDB_IMM = 8'hC4;
  localparam logic [BYTE_W-1:0] OPC_BRA_REL  = 8'h20;
  localparam logic [BYTE_W-1:0] OPC_HALT     = 8'h3E;

  typedef enum logic [2:0] {
    ST_FETCH, ST_OPND_LO, ST_OPND_HI, ST_DATA, ST_HALT
  } state_e;

  typedef enum logic [2:0] {
    CLS_NOP, CLS_HALT, CLS_IMM, CLS_DIR, CLS_BRA
  } cls_e;

  typedef enum logic [2:0] {
    ALU_NONE, ALU_ADD_A, ALU_AND_A, ALU_AND_B, ALU_LOAD_A
  } alu_op_e;

  typedef struct packed {
    cls_e    cls;
    alu_op_e alu_op;
  } decode_t;
endpackage

// File: rtl/byte_exec_decode.sv
module byte_exec_decode
  import byte_exec_pkg::*;
(
  input  logic [BYTE_W-1:0] opcode_i,
  output decode_t           dec_o
);
  always_comb begin
    dec_o = '{cls: CLS_NOP, alu_op: ALU_NONE};
    case (opcode_i)
      OPC_LDA_DIR:  dec_o = '{cls: CLS_DIR,  alu_op: ALU_LOAD_A};
      OPC_ADDA_DIR: dec_o = '{cls: CLS_DIR,  alu_op: ALU_ADD_A};
      OPC_ADDA_IMM: dec_o = '{cls: CLS_IMM,  alu_op: ALU_ADD_A};
      OPC_ANDA_IMM: dec_o = '{cls: CLS_IMM,  alu_op: ALU_AND_A};
      OPC_ANDB_IMM: dec_o = '{cls: CLS_IMM,  alu_op: ALU_AND_B};
      OPC_BRA_REL:  dec_o = '{cls: CLS_BRA,  alu_op: ALU_NONE};
      OPC_HALT:     dec_o = '{cls: CLS_HALT, alu_op: ALU_NONE};
      default:      dec_o = '{cls: CLS_NOP,  alu_op: ALU_NONE};
    endcase
  end
endmodule

// File: rtl/byte_exec_pc.sv
module byte_exec_pc
  import byte_exec_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              branch_i,
  input  logic [BYTE_W-1:0] disp_i,
  output logic [ADDR_W-1:0] pc_o
);
  localparam int EXT_W = ADDR_W - BYTE_W;

  logic [ADDR_W-1:0] disp_ext;
  assign disp_ext = {{EXT_W{disp_i[BYTE_W-1]}}, disp_i};

  // during the displacement read pc already points at opcode+1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pc_o <= RESET_PC;
    else if (branch_i) pc_o <= pc_o + ADDR_W'(1) + disp_ext;
    else if (inc_i)    pc_o <= pc_o + ADDR_W'(1);
  end

  assert_step_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !branch_i) |=> pc_o == $past(pc_o) + ADDR_W'(1));
endmodule

// File: rtl/byte_exec_alu.sv
module byte_exec_alu
  import byte_exec_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ACC_A_INIT = '0,
  parameter logic [BYTE_W-1:0] ACC_B_INIT = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  alu_op_e           op_i,
  input  logic [BYTE_W-1:0] operand_i,
  output logic [BYTE_W-1:0] acc_a_o,
  output logic [BYTE_W-1:0] acc_b_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_a_o <= ACC_A_INIT;
      acc_b_o <= ACC_B_INIT;
    end else if (en_i) begin
      case (op_i)
        ALU_ADD_A:  acc_a_o <= acc_a_o + operand_i;
        ALU_AND_A:  acc_a_o <= acc_a_o & operand_i;
        ALU_AND_B:  acc_b_o <= acc_b_o & operand_i;
        ALU_LOAD_A: acc_a_o <= operand_i;
        default: ;
      endcase
    end
  end

  assert_andb_keeps_a_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == ALU_AND_B) |=> $stable(acc_a_o) && (acc_b_o == ($past(acc_b_o) & $past(operand_i))));

  assert_add_keeps_b_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && op_i == ALU_ADD_A) |=> $stable(acc_b_o));
endmodule

// File: rtl/byte_exec_core.sv
module byte_exec_core
  import byte_exec_pkg::*;
#(
  parameter logic [ADDR_W-1:0] RESET_PC   = '0,
  parameter logic [BYTE_W-1:0] ACC_A_INIT = '0,
  parameter logic [BYTE_W-1:0] ACC_B_INIT = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              halt_o,
  output logic [BYTE_W-1:0] acc_a_o,
  output logic [BYTE_W-1:0] acc_b_o,
  output logic [ADDR_W-1:0] pc_o
);
  state_e            state_q, state_d;
  logic [BYTE_W-1:0] op_q, lo_q, hi_q, dec_in;
  decode_t           dec;
  logic              pc_inc, pc_branch, alu_en;
  logic [ADDR_W-1:0] pc_q;

  // opcode is decoded straight off the bus in its fetch cycle
  assign dec_in = (state_q == ST_FETCH) ? mem_rdata_i : op_q;

  byte_exec_decode u_dec (
    .opcode_i (dec_in),
    .dec_o    (dec)
  );

  byte_exec_pc #(.RESET_PC(RESET_PC)) u_pc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (pc_inc),
    .branch_i (pc_branch),
    .disp_i   (mem_rdata_i),
    .pc_o     (pc_q)
  );

  byte_exec_alu #(.ACC_A_INIT(ACC_A_INIT), .ACC_B_INIT(ACC_B_INIT)) u_alu (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (alu_en),
    .op_i      (dec.alu_op),
    .operand_i (mem_rdata_i),
    .acc_a_o   (acc_a_o),
    .acc_b_o   (acc_b_o)
  );

  always_comb begin
    state_d    = state_q;
    pc_inc     = 1'b0;
    pc_branch  = 1'b0;
    alu_en     = 1'b0;
    mem_addr_o = pc_q;
    case (state_q)
      ST_FETCH: begin
        pc_inc = 1'b1;
        case (dec.cls)
          CLS_HALT: state_d = ST_HALT;
          CLS_NOP:  state_d = ST_FETCH;
          default:  state_d = ST_OPND_LO;
        endcase
      end
      ST_OPND_LO: begin
        case (dec.cls)
          CLS_BRA: begin
            pc_branch = 1'b1;
            state_d   = ST_FETCH;
          end
          CLS_IMM: begin
            pc_inc  = 1'b1;
            alu_en  = 1'b1;
            state_d = ST_FETCH;
          end
          default: begin
            pc_inc  = 1'b1;
            state_d = ST_OPND_HI;
          end
        endcase
      end
      ST_OPND_HI: begin
        pc_inc  = 1'b1;
        state_d = ST_DATA;
      end
      ST_DATA: begin
        mem_addr_o = {hi_q, lo_q};
        alu_en     = 1'b1;
        state_d    = ST_FETCH;
      end
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      op_q    <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_FETCH)   op_q <= mem_rdata_i;
      if (state_q == ST_OPND_LO) lo_q <= mem_rdata_i;
      if (state_q == ST_OPND_HI) hi_q <= mem_rdata_i;
    end
  end

  assign halt_o      = (state_q == ST_HALT);
  assign pc_o        = pc_q;
  assign mem_wdata_o = acc_a_o;
  assign mem_we_o    = 1'b0;

  assert_nop_one_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH && dec.cls == CLS_NOP) |=> state_q == ST_FETCH && $stable(acc_a_o) && $stable(acc_b_o));

  assert_imm_two_cycles_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OPND_LO && dec.cls == CLS_IMM) |=> state_q == ST_FETCH && pc_q == $past(pc_q) + ADDR_W'(1));

  assert_low_first_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_OPND_HI |=> state_q == ST_DATA && mem_addr_o == {$past(mem_rdata_i), lo_q});

  assert_branch_target_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OPND_LO && dec.cls == CLS_BRA)
    |=> pc_q == $past(pc_q, 2) + ADDR_W'(2) + {{(ADDR_W-BYTE_W){$past(mem_rdata_i[BYTE_W-1])}}, $past(mem_rdata_i)});

  assert_halt_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o && $stable(pc_q) && $stable(acc_a_o) && $stable(acc_b_o) && $stable(mem_addr_o));

  assert_data_ends_instr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DATA |=> state_q == ST_FETCH);
endmodule

// File: tb/tb_byte_exec_core.sv
`timescale 1ns/1ps
module tb_byte_exec_core;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata, mem_wdata, acc_a, acc_b;
  logic        mem_we, halt;
  logic [15:0] pc;

  logic [7:0]  mem [0:4095];
  logic [15:0] exp_q[$];
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  assign mem_rdata = mem[mem_addr[11:0]];

  byte_exec_core #(.RESET_PC(16'h0000), .ACC_A_INIT(8'h67), .ACC_B_INIT(8'h9D)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .mem_wdata_o(mem_wdata), .mem_we_o(mem_we), .halt_o(halt),
    .acc_a_o(acc_a), .acc_b_o(acc_b), .pc_o(pc));

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] rd(logic [15:0] a);
    return mem[a[11:0]];
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
  endtask

  task automatic poke(logic [15:0] a, logic [7:0] b);
    mem[a[11:0]] = b;
  endtask

  // instruction-level interpreter: per-cycle address list and end state
  task automatic model_prog(output logic [7:0] ma, output logic [7:0] mb,
                            output logic [15:0] mpc, output bit ok);
    logic [15:0] p;
    logic [7:0]  a, b, op, lo, hi, d;
    p = 16'h0000; a = 8'h67; b = 8'h9D; ok = 1'b0;
    exp_q.delete();
    for (int step = 0; step < 1000; step++) begin
      op = rd(p);
      exp_q.push_back(p);
      if (op == 8'h3E) begin
        p = p + 16'd1;
        ok = 1'b1;
        break;
      end else if (op == 8'hC6 || op == 8'h84 || op == 8'hC4 || op == 8'h20) begin
        lo = rd(p + 16'd1);
        exp_q.push_back(p + 16'd1);
        if (op == 8'hC6) a = a + lo;
        if (op == 8'h84) a = a & lo;
        if (op == 8'hC4) b = b & lo;
        if (op == 8'h20) p = p + 16'd2 + {{8{lo[7]}}, lo};
        else             p = p + 16'd2;
      end else if (op == 8'h3A || op == 8'hBB) begin
        lo = rd(p + 16'd1);
        hi = rd(p + 16'd2);
        exp_q.push_back(p + 16'd1);
        exp_q.push_back(p + 16'd2);
        exp_q.push_back({hi, lo});
        d = rd({hi, lo});
        if (op == 8'h3A) a = d;
        else             a = a + d;
        p = p + 16'd3;
      end else begin
        p = p + 16'd1;
      end
    end
    ma = a; mb = b; mpc = p;
  endtask

  task automatic run_prog(string req, logic [7:0] ea, logic [7:0] eb, logic [15:0] epc);
    logic [7:0]  ma, mb;
    logic [15:0] mpc, e;
    bit          ok;
    model_prog(ma, mb, mpc, ok);
    chk(ok, req, "program reaches halt in model", int'(ok), 1);
    rst_ni = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(pc == 16'h0000, "R1", "reset pc", int'(pc), 0);
    chk(acc_a == 8'h67, "R1", "reset A", int'(acc_a), 'h67);
    chk(acc_b == 8'h9D, "R1", "reset B", int'(acc_b), 'h9D);
    chk(halt == 1'b0, "R1", "reset halt", int'(halt), 0);
    chk(mem_addr == 16'h0000, "R1", "first fetch address", int'(mem_addr), 0);
    rst_ni = 1'b1;
    while (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk(mem_addr == e, "R10", "cycle address", int'(mem_addr), int'(e));
      chk(mem_we == 1'b0, "R9", "write enable", int'(mem_we), 0);
      @(negedge clk);
    end
    chk(halt == 1'b1, "R8", "halt raised", int'(halt), 1);
    chk(acc_a == ea, req, "final A", int'(acc_a), int'(ea));
    chk(acc_b == eb, req, "final B", int'(acc_b), int'(eb));
    chk(pc == epc, req, "final pc", int'(pc), int'(epc));
    chk(acc_a == ma && acc_b == mb && pc == mpc, req, "model end pc", int'(pc), int'(mpc));
    repeat (3) @(negedge clk);
    chk(halt == 1'b1, "R8", "halt held", int'(halt), 1);
    chk(pc == epc, "R8", "pc frozen", int'(pc), int'(epc));
    chk(acc_a == ea && acc_b == eb, "R8", "A frozen", int'(acc_a), int'(ea));
    chk(mem_addr == epc, "R8", "address frozen", int'(mem_addr), int'(epc));
    chk(mem_we == 1'b0, "R9", "write enable at halt", int'(mem_we), 0);
  endtask

  initial begin
    // immediates, unknown opcode as no-op
    clear_mem();
    poke(16'h0000, 8'h84); poke(16'h0001, 8'h55);
    poke(16'h0002, 8'hC4); poke(16'h0003, 8'hA5);
    poke(16'h0004, 8'hC6); poke(16'h0005, 8'h0C);
    poke(16'h0006, 8'hC6); poke(16'h0007, 8'hF0);
    poke(16'h0008, 8'h77);
    poke(16'h0009, 8'h3E);
    run_prog("R3 R4 R2", 8'h41, 8'h85, 16'h000A);

    // direct load and add, low address byte first
    clear_mem();
    poke(16'h0000, 8'h3A); poke(16'h0001, 8'h00); poke(16'h0002, 8'h02);
    poke(16'h0003, 8'hBB); poke(16'h0004, 8'h01); poke(16'h0005, 8'h02);
    poke(16'h0006, 8'hBB); poke(16'h0007, 8'h10); poke(16'h0008, 8'h00);
    poke(16'h0009, 8'h3E);
    poke(16'h0010, 8'h05);
    poke(16'h0200, 8'h23); poke(16'h0201, 8'hF0);
    run_prog("R5 R6", 8'h18, 8'h9D, 16'h000A);

    // forward then backward branch
    clear_mem();
    poke(16'h0000, 8'h20); poke(16'h0001, 8'h05);
    poke(16'h0002, 8'hC6); poke(16'h0003, 8'h01);
    poke(16'h0004, 8'h20); poke(16'h0005, 8'h03);
    poke(16'h0007, 8'h20); poke(16'h0008, 8'hF9);
    poke(16'h0009, 8'h3E);
    run_prog("R7", 8'h68, 8'h9D, 16'h000A);

    // backward branch wrapping below zero to 0xFF82
    clear_mem();
    poke(16'h0000, 8'h20); poke(16'h0001, 8'h80);
    poke(16'hFF82, 8'h3E);
    run_prog("R7", 8'h67, 8'h9D, 16'hFF83);

    // undefined opcodes only
    clear_mem();
    poke(16'h0000, 8'h00); poke(16'h0001, 8'hFF); poke(16'h0002, 8'h3E);
    run_prog("R2", 8'h67, 8'h9D, 16'h0003);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog: actual no halt expected halt");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule